// File: doc/BRIEF.md
# Long-Press Reset and Recovery Controller

This block watches one active-low reset pushbutton and turns each press into an action. A press is accepted only if it survives a confirmation window. Once accepted, the time the button stays down decides the outcome. A short hold starts a normal reboot. A long hold starts a recovery reboot, which arms the factory-defaults source. A hold of middling length does nothing.

The recovery decision is kept in a sticky flag. Only the power-on reset and a dedicated software clear input can drop it; the reboot pulse that the block issues itself leaves it alone. The flag steers two active-low chip selects. One enables the writable settings memory and the other enables the fixed defaults ROM, so boot code reads from whichever store the last press chose. After boot code has written good values back into the settings memory, it clears the flag. Every duration is a parameter counted in clock cycles, and the button passes through a two-flop synchroniser before any timing starts.

Top module: `rrc_reset_ctrl`

## Requirements
- R1: A press is accepted only if the synchronised button is still pressed in the last cycle of a CONFIRM_CYC-cycle window that opens when a press is first seen while idle. Otherwise the block returns to idle with no reboot and no flag change. Bounce inside the window is ignored.
- R2: An accepted press released before SHORT_CYC cycles of holding produces exactly one reboot pulse and leaves the recovery flag at 0.
- R3: An accepted press released after at least SHORT_CYC held cycles, but before the long threshold, produces no reboot and does not change the flag.
- R4: An accepted press held for LONG_CYC cycles sets the recovery flag and starts the reboot pulse on the same clock edge, without waiting for release.
- R5: reboot_req is active high and stays high for exactly PULSE_CYC cycles after each trigger.
- R6: The recovery flag is cleared only by rst_n low or by flag_clr high at a clock edge. The block's own reboot pulse does not clear it.
- R7: With the flag at 1, cs_dflt_n is 0 and cs_cfg_n is 1. With the flag at 0, cs_dflt_n is 1 and cs_cfg_n is 0.
- R8: After an accepted press ends (by release or by the long trigger), button activity is ignored until the button has been seen released for QUIET_CYC consecutive cycles. One held press can therefore trigger at most once.
- R9: When the long-hold set and flag_clr fall on the same edge, the flag ends up at 1.
- R10: After a synchronous reset (rst_n low at a clock edge), reboot_req is 0, the flag is 0, cs_cfg_n is 0 and cs_dflt_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| btn_n | input | 1 | Asynchronous pushbutton, low when pressed |
| flag_clr | input | 1 | Software clear of the recovery flag |
| reboot_req | output | 1 | Active-high reboot pulse, PULSE_CYC cycles |
| recov_flag | output | 1 | Sticky recovery flag |
| cs_cfg_n | output | 1 | Active-low select of the settings memory |
| cs_dflt_n | output | 1 | Active-low select of the defaults ROM |

## Verification
A long-hold set and a software clear can reach the recovery flag on the same edge. The bench provokes this by holding flag_clr high for the whole of a long press, so the clear is present when the long threshold expires. It then checks that the flag reads 1 in the first cycle of the reboot pulse, because the set wins, and reads 0 one cycle later, because the clear is still applied. A cycle-accurate behavioural model, compared on every clock, confirms that the chip selects follow both transitions.

// File: rtl/rrc_pkg.sv
// Shared types for the reset/recovery controller.
package rrc_pkg;
    // Phases of a button press as seen by the press timer.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_CONFIRM = 2'd1,
        PH_HELD    = 2'd2,
        PH_QUIET   = 2'd3
    } press_phase_t;
endpackage

// File: rtl/rrc_sync2.sv
// Two-flop synchroniser for a single asynchronous level.
// Assumes the input is slow compared with clk; the reset value is a parameter.
module rrc_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    // Capture the asynchronous level, then re-register it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rrc_press_timer.sv
// Press timer: confirms a press, measures the hold and classifies it.
// Emits a one-cycle short_fire or long_fire strobe, then waits for the
// button to stay released for QUIET_CYC cycles. Assumes a synchronised input.
module rrc_press_timer
    import rrc_pkg::*;
#(
    parameter int CONFIRM_CYC = 8,
    parameter int SHORT_CYC   = 40,
    parameter int LONG_CYC    = 120,
    parameter int QUIET_CYC   = 10,
    parameter int CW          = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pressed,
    output logic short_fire,
    output logic long_fire
);
    localparam logic [CW-1:0] CONF_LAST  = CW'(CONFIRM_CYC - 1);
    localparam logic [CW-1:0] SHORT_LIM  = CW'(SHORT_CYC);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] QUIET_LAST = CW'(QUIET_CYC - 1);

    press_phase_t  phase;
    logic [CW-1:0] cnt;

    // Classify the end of a held press (combinational strobes).
    always_comb begin
        short_fire = (phase == PH_HELD) && !pressed && (cnt < SHORT_LIM);
        long_fire  = (phase == PH_HELD) && pressed && (cnt == LONG_LAST);
    end

    // Walk a press through confirm, hold and quiet phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (pressed) phase <= PH_CONFIRM;
                end
                PH_CONFIRM: begin
                    if (cnt == CONF_LAST) begin
                        cnt   <= '0;
                        phase <= pressed ? PH_HELD : PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HELD: begin
                    if (!pressed || cnt == LONG_LAST) begin
                        cnt   <= '0;
                        phase <= PH_QUIET;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_QUIET: begin
                    if (pressed) begin
                        cnt <= '0;
                    end else if (cnt == QUIET_LAST) begin
                        cnt   <= '0;
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    // R1
    held_needs_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_CONFIRM && phase == PH_HELD) |-> $past(pressed));

    // R8
    fire_enters_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_fire || long_fire) |=> (phase == PH_QUIET));

    // R8
    quiet_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_QUIET && pressed) |=> !(short_fire || long_fire));
endmodule

// File: rtl/rrc_recov_flag.sv
// Sticky recovery flag: set by a long hold, cleared by software or power-on
// reset only. A set and a clear on the same edge leave the flag set.
module rrc_recov_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

    // R6
    fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag) && $past(rst_n)) |-> $past(clr));
endmodule

// File: rtl/rrc_pulse_gen.sv
// Stretches a one-cycle trigger into an active-high pulse of PULSE_CYC cycles.
// A trigger during a pulse restarts the count.
module rrc_pulse_gen #(
    parameter int PULSE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] LOAD = PW'(PULSE_CYC);

    logic [PW-1:0] left;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)             left <= '0;
        else if (trig)          left <= LOAD;
        else if (left != '0)    left <= left - 1'b1;
    end

    assign pulse = (left != '0);

    // R5
    trig_starts_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse);

    // R5
    pulse_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(trig));
endmodule

// File: rtl/rrc_reset_ctrl.sv
// Top of the long-press reset and recovery controller.
// Synchronises the button, times each press, issues reboot pulses and
// steers the two active-low chip selects from the sticky recovery flag.
// Assumes rst_n is the power-on reset, not the reboot this block requests.
module rrc_reset_ctrl #(
    parameter int CONFIRM_CYC = 25_000_000,
    parameter int SHORT_CYC   = 250_000_000,
    parameter int LONG_CYC    = 750_000_000,
    parameter int QUIET_CYC   = 25_000_000,
    parameter int PULSE_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic flag_clr,
    output logic reboot_req,
    output logic recov_flag,
    output logic cs_cfg_n,
    output logic cs_dflt_n
);
    localparam int MAXC1 = (CONFIRM_CYC > QUIET_CYC) ? CONFIRM_CYC : QUIET_CYC;
    localparam int MAXC  = (LONG_CYC > MAXC1) ? LONG_CYC : MAXC1;
    localparam int CW    = $clog2(MAXC + 1);

    logic btn_sync_n;
    logic pressed;
    logic short_fire;
    logic long_fire;
    logic fire;

    rrc_sync2 #(.RST_VAL(1'b1)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(btn_n), .q(btn_sync_n)
    );

    assign pressed = ~btn_sync_n;

    rrc_press_timer #(
        .CONFIRM_CYC(CONFIRM_CYC), .SHORT_CYC(SHORT_CYC),
        .LONG_CYC(LONG_CYC), .QUIET_CYC(QUIET_CYC), .CW(CW)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .pressed(pressed),
        .short_fire(short_fire), .long_fire(long_fire)
    );

    assign fire = short_fire | long_fire;

    rrc_recov_flag flag_i (
        .clk(clk), .rst_n(rst_n), .set(long_fire), .clr(flag_clr), .flag(recov_flag)
    );

    rrc_pulse_gen #(.PULSE_CYC(PULSE_CYC)) pulse_i (
        .clk(clk), .rst_n(rst_n), .trig(fire), .pulse(reboot_req)
    );

    // Select the defaults ROM while recovering, else the settings memory.
    always_comb begin
        cs_dflt_n = ~recov_flag;
        cs_cfg_n  = recov_flag;
    end

    // R2
    short_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (short_fire && !recov_flag) |=> !recov_flag);

    // R4
    long_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        long_fire |=> (recov_flag && reboot_req && !cs_dflt_n));
endmodule

// File: tb/rrc_reset_ctrl_tb_top.sv
// Bench: behavioural cycle model compared on every clock plus scenario checks.
module rrc_reset_ctrl_tb_top;
    localparam int CONF = 8, SHRT = 40, LNG = 120, QUI = 10, PUL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic flag_clr = 1'b0;
    logic reboot_req, recov_flag, cs_cfg_n, cs_dflt_n;

    int n_chk = 0, n_fail = 0, reboots = 0;
    logic prev_req = 1'b0;

    always #2 clk = ~clk;

    rrc_reset_ctrl #(.CONFIRM_CYC(CONF), .SHORT_CYC(SHRT), .LONG_CYC(LNG),
                     .QUIET_CYC(QUI), .PULSE_CYC(PUL)) dut_i (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .flag_clr(flag_clr),
        .reboot_req(reboot_req), .recov_flag(recov_flag),
        .cs_cfg_n(cs_cfg_n), .cs_dflt_n(cs_dflt_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model: pipeline of seen levels, a press mode and elapsed time.
    bit m_seen[$];
    int m_mode = 0, m_t = 0, m_pulse = 0;
    bit m_flag = 0;

    always @(posedge clk) begin
        bit p, shortf, longf;
        if (!rst_n) begin
            m_seen = '{0, 0}; m_mode = 0; m_t = 0; m_pulse = 0; m_flag = 0;
        end else begin
            p = m_seen[0];
            void'(m_seen.pop_front());
            m_seen.push_back(!btn_n);
            shortf = (m_mode == 2) && !p && (m_t < SHRT);
            longf  = (m_mode == 2) && p && (m_t == LNG - 1);
            case (m_mode)
                0: begin m_t = 0; if (p) m_mode = 1; end
                1: if (m_t == CONF - 1) begin m_t = 0; m_mode = p ? 2 : 0; end
                   else m_t++;
                2: if (!p || m_t == LNG - 1) begin m_t = 0; m_mode = 3; end
                   else m_t++;
                default: if (p) m_t = 0;
                   else if (m_t == QUI - 1) begin m_t = 0; m_mode = 0; end
                   else m_t++;
            endcase
            if (shortf || longf) m_pulse = PUL;
            else if (m_pulse > 0) m_pulse--;
            if (longf) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    // Per-cycle comparison and reboot edge counting, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(reboot_req == (m_pulse > 0), "R5 reboot_req", reboot_req, m_pulse > 0);
            chk(recov_flag == m_flag, "R6 recov_flag", recov_flag, m_flag);
            chk(cs_dflt_n == !m_flag && cs_cfg_n == m_flag, "R7 chip selects",
                {cs_cfg_n, cs_dflt_n}, {m_flag, !m_flag});
            if (reboot_req && !prev_req) reboots++;
            prev_req = reboot_req;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic press(input int n);
        @(negedge clk); btn_n = 1'b0;
        idle(n);
        btn_n = 1'b1;
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        // R10 reset state
        chk(!reboot_req && !recov_flag && !cs_cfg_n && cs_dflt_n, "R10 reset state",
            {reboot_req, recov_flag, cs_cfg_n, cs_dflt_n}, 4'b0001);
        @(negedge clk); rst_n = 1'b1;
        idle(10);

        // R1 glitch shorter than confirm window is dropped
        reboots = 0; press(4); idle(60);
        chk(reboots == 0, "R1 glitch", reboots, 0);

        // R1 bounce inside the window, then a short hold is accepted
        reboots = 0;
        press(2); idle(1); press(2); idle(1); press(25); idle(60);
        chk(reboots == 1, "R1 bounce accepted", reboots, 1);

        // R2 short press: one reboot, flag stays 0
        reboots = 0; press(20); idle(60);
        chk(reboots == 1, "R2 short reboot", reboots, 1);
        chk(recov_flag == 0, "R2 flag", recov_flag, 0);

        // R3 medium press: nothing
        reboots = 0; press(CONF + 80); idle(60);
        chk(reboots == 0, "R3 medium", reboots, 0);
        chk(recov_flag == 0, "R3 flag", recov_flag, 0);

        // R4 and R8 long hold kept down: one recovery reboot only
        reboots = 0; press(CONF + LNG + 80);
        chk(recov_flag == 1, "R4 flag set", recov_flag, 1);
        chk(cs_dflt_n == 0 && cs_cfg_n == 1, "R7 rom selected", {cs_cfg_n, cs_dflt_n}, 2'b10);
        // R8 re-press inside the quiet interval is ignored
        idle(4); press(30); idle(60);
        chk(reboots == 1, "R8 single trigger", reboots, 1);

        // R6 own reboot left flag set; short press also keeps it
        reboots = 0; press(20); idle(60);
        chk(recov_flag == 1, "R6 flag survives reboot", recov_flag, 1);
        chk(reboots == 1, "R2 short while recovering", reboots, 1);

        // R6 software clear
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk(recov_flag == 0, "R6 software clear", recov_flag, 0);
        chk(cs_cfg_n == 0 && cs_dflt_n == 1, "R7 settings selected", {cs_cfg_n, cs_dflt_n}, 2'b01);
        idle(10);

        // R9 clear held across the long threshold: set wins, then clear applies
        flag_clr = 1'b1;
        fork
            press(CONF + LNG + 20);
            begin
                do @(negedge clk); while (!reboot_req);
                chk(recov_flag == 1, "R9 set wins", recov_flag, 1);
                @(negedge clk);
                chk(recov_flag == 0, "R9 clear after", recov_flag, 0);
            end
        join
        flag_clr = 1'b0;
        idle(60);

        // R10 reset in the middle of a pulse
        press(20); idle(8);
        @(negedge clk); rst_n = 1'b0; @(negedge clk);
        chk(!reboot_req && !recov_flag && cs_dflt_n && !cs_cfg_n, "R10 mid reset",
            {reboot_req, recov_flag, cs_cfg_n, cs_dflt_n}, 4'b0001);
        rst_n = 1'b1; idle(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule